// File: doc/BRIEF.md
# Serial Flash Quad Read Engine with Continuous Mode

This block is the read side of a serial flash device model. It follows the serial clock one edge at a time. It collects the command byte, address and dummy field from one or four input lanes, and then streams bytes from the memory array onto the output lanes. Three read commands are served: a one-lane fast read, a read that takes its address on one lane and returns data on four, and a read that uses four lanes both ways. Other command bytes are left to the rest of the device.

After either four-lane read, a mode bit taken from the dummy field decides what the next transaction looks like. If the bit is low, the next chip-select period skips the command byte and begins at once with a four-lane address. This is the continuous, execute-in-place style of access. If the bit is high, the device returns to ordinary one-lane command decoding. The memory array itself sits outside the block and is read through an address and data port. While the program/erase engine reports a busy cycle, every returned byte is zero.

Each serial clock edge is given as a one-cycle `tick` strobe. The output lanes change only on such a strobe, or when the chip is deselected.

Top module: `qread_engine`

## Requirements
- R1: Fast read, command 0x0B. The command and the 24-bit address are sent MSB first on io_in[0], one bit per tick, so the address is complete at tick 32. Ticks 33 to 40 are dummy. The first byte is fetched at tick 40, and io_oe becomes 4'b0010 at that tick. From tick 41 on, io_out[1] carries the data MSB first, one bit per tick.
- R2: Quad output read, command 0x6B. The address comes on io_in[0], as for R1. Eight four-lane ticks of mode/dummy data follow. The first byte is fetched at tick 40 with io_oe = 4'hF. From tick 41 on, io_out[3:0] carries one nibble per tick, high nibble first.
- R3: Quad I/O read, command 0xEB. The command is sent on one lane. The address then follows as six nibbles on io_in[3:0], most significant nibble first, and eight four-lane mode/dummy ticks come after it. The first byte is fetched at tick 22, and nibbles appear from tick 23.
- R4: In either four-lane read, bit 7 of the first byte after the address is the mode bit. That bit is io_in[3] on the first mode tick. If the mode bit is 0, the next transaction is continuous (R5). If it is 1, the next transaction begins with a command byte.
- R5: A continuous transaction carries no command byte. It sends six address nibbles and then eight mode/dummy nibbles. The first byte is fetched at tick 14, and nibbles appear from tick 15. The R4 rule then decides the transaction after it.
- R6: A byte fetched while wip is high is returned as 0x00. The read address still advances.
- R7: The read address is the received address masked to ADDR_W bits. It increases by one after every fetched byte and wraps from the top of the array to zero.
- R8: A command byte that is not one of the three read commands leaves io_oe at zero and io_out at zero until deselect. The next transaction begins with a command byte.
- R9: While cs_n is high, outputs clear on the next clock. In a cycle where the chip is selected and no tick arrives, io_out, io_oe and mem_addr hold their values.
- R10: Lane encoding. In one-lane output, only io_out[1] may be high. In four-lane output, io_out[3:0] is the current nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| tick | input | 1 | One serial clock edge in this cycle |
| io_in | input | 4 | Input lanes; lane 0 in one-lane phases |
| wip | input | 1 | Program/erase busy flag |
| mem_rdata | input | 8 | Array byte at mem_addr |
| io_out | output | 4 | Output lanes |
| io_oe | output | 4 | Per-lane output enable |
| mem_addr | output | ADDR_W | Current read address |

## Verification
Several rules are checked on every cycle by properties:
- outputs clear after deselect;
- outputs and address freeze when no tick arrives;
- only lane 1 carries data in one-lane output;
- once driving starts, the lane enable stays fixed until deselect;
- the address only holds or steps by one, wrapping, while data flows.

The tick at which each command's first byte appears, and the decision on the mode bit across transaction boundaries, cannot be checked by those properties. The same holds for busy zeroing, masking of the address above the array and the ignoring of other commands. These show only through the bench's scenarios, where a reference model predicts every output nibble or bit.

// File: rtl/qread_pkg.sv
package qread_pkg;

    typedef logic [7:0] cnt_t;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_FAST,
        PH_QOUT,
        PH_QIO,
        PH_CONT,
        PH_SKIP
    } qread_phase_e;

    localparam logic [7:0] OPC_FAST = 8'h0B;
    localparam logic [7:0] OPC_QOUT = 8'h6B;
    localparam logic [7:0] OPC_QIO  = 8'hEB;

    localparam cnt_t MARK_OPC       = 8'd8;
    localparam cnt_t MARK_ADDR      = 8'd32;
    localparam cnt_t MARK_CONT_ADDR = 8'd24;
    localparam cnt_t MARK_FAST_DATA = 8'd40;
    localparam cnt_t MARK_QUAD_DATA = 8'd64;
    localparam cnt_t MARK_CONT_DATA = 8'd56;
    localparam cnt_t CNT_FOLD_AT    = 8'd128;
    localparam cnt_t CNT_FOLD_BY    = 8'd56;

endpackage

// File: rtl/qread_rx.sv
module qread_rx
    import qread_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              tick,
    input  logic              quad,
    input  logic [3:0]        io_in,
    output logic              step,
    output cnt_t              cnt_nx,
    output logic [ADDR_W-1:0] field_nx,
    output logic              mode_nx
);

    typedef struct packed {
        logic [31:0] sh;
        cnt_t        cnt;
    } rx_s;

    rx_s  q, d, adv;
    cnt_t cnt_raw;

    always_comb begin
        cnt_raw = q.cnt + (quad ? 8'd4 : 8'd1);
        adv.cnt = (cnt_raw >= CNT_FOLD_AT) ? cnt_raw - CNT_FOLD_BY : cnt_raw;
        adv.sh  = quad ? {q.sh[27:0], io_in} : {q.sh[30:0], io_in[0]};
        d = q;
        if (cs_n) begin
            d = '0;
        end else if (tick) begin
            d = adv;
        end
        step     = !cs_n && tick;
        cnt_nx   = adv.cnt;
        field_nx = adv.sh[ADDR_W-1:0];
        mode_nx  = adv.sh[31];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/qread_seq.sv
module qread_seq
    import qread_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              step,
    input  cnt_t              cnt_nx,
    input  logic [ADDR_W-1:0] field_nx,
    input  logic              mode_nx,
    output logic              quad,
    output logic              load,
    output logic              data_on,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        qread_phase_e      phase;
        logic              quad;
        logic              active;
        logic              mode_zero;
        logic              data_on;
        logic [ADDR_W-1:0] addr;
    } seq_s;

    seq_s q, d;
    logic fetch;
    logic on_byte;

    always_comb begin
        d       = q;
        fetch   = 1'b0;
        on_byte = (cnt_nx[2:0] == 3'd0);
        if (cs_n) begin
            if (q.active) begin
                d.phase = q.mode_zero ? PH_CONT : PH_OPC;
                d.quad  = q.mode_zero;
            end
            d.active    = 1'b0;
            d.mode_zero = 1'b0;
            d.data_on   = 1'b0;
        end else if (step) begin
            d.active = 1'b1;
            unique case (q.phase)
                PH_OPC: begin
                    if (cnt_nx == MARK_OPC) begin
                        unique case (field_nx[7:0])
                            OPC_FAST: d.phase = PH_FAST;
                            OPC_QOUT: d.phase = PH_QOUT;
                            OPC_QIO: begin
                                d.phase = PH_QIO;
                                d.quad  = 1'b1;
                            end
                            default:  d.phase = PH_SKIP;
                        endcase
                    end
                end
                PH_FAST: begin
                    if (cnt_nx == MARK_ADDR) d.addr = field_nx;
                    fetch = (cnt_nx >= MARK_FAST_DATA) && on_byte;
                end
                PH_QOUT, PH_QIO: begin
                    if (cnt_nx == MARK_ADDR) begin
                        d.addr = field_nx;
                        d.quad = 1'b1;
                    end
                    if (cnt_nx == MARK_QUAD_DATA) d.mode_zero = !mode_nx;
                    fetch = (cnt_nx >= MARK_QUAD_DATA) && on_byte;
                end
                PH_CONT: begin
                    if (cnt_nx == MARK_CONT_ADDR) d.addr = field_nx;
                    if (cnt_nx == MARK_CONT_DATA) d.mode_zero = !mode_nx;
                    fetch = (cnt_nx >= MARK_CONT_DATA) && on_byte;
                end
                default: ;
            endcase
            if (fetch) begin
                d.data_on = 1'b1;
                d.addr    = q.addr + ADDR_W'(1);
            end
        end
        quad    = q.quad;
        load    = fetch;
        data_on = q.data_on;
        addr    = q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_OPC;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/qread_tx.sv
module qread_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       step,
    input  logic       quad,
    input  logic       load,
    input  logic       data_on,
    input  logic       wip,
    input  logic [7:0] rd_byte,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);

    typedef struct packed {
        logic [11:0] sh;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d = q;
        if (cs_n) begin
            d.sh = '0;
        end else if (step) begin
            d.sh = quad ? {q.sh[7:0], 4'h0} : {q.sh[10:0], 1'b0};
            if (load) d.sh[7:0] = wip ? 8'h00 : rd_byte;
        end
        io_out = quad ? q.sh[11:8] : {2'b00, q.sh[8], 1'b0};
        io_oe  = data_on ? (quad ? 4'hF : 4'b0010) : 4'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/qread_engine.sv
module qread_engine
    import qread_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              tick,
    input  logic [3:0]        io_in,
    input  logic              wip,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int MIN_W = 8;
    localparam int MAX_W = 24;

    logic              step;
    cnt_t              cnt_nx;
    logic [ADDR_W-1:0] field_nx;
    logic              mode_nx;
    logic              quad;
    logic              load;
    logic              data_on;

    generate
        if (ADDR_W < MIN_W || ADDR_W > MAX_W) begin : g_bad_width
            initial $error("qread_engine: ADDR_W out of range");
        end
    endgenerate

    qread_rx #(.ADDR_W(ADDR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .tick     (tick),
        .quad     (quad),
        .io_in    (io_in),
        .step     (step),
        .cnt_nx   (cnt_nx),
        .field_nx (field_nx),
        .mode_nx  (mode_nx)
    );

    qread_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .step     (step),
        .cnt_nx   (cnt_nx),
        .field_nx (field_nx),
        .mode_nx  (mode_nx),
        .quad     (quad),
        .load     (load),
        .data_on  (data_on),
        .addr     (mem_addr)
    );

    qread_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .step    (step),
        .quad    (quad),
        .load    (load),
        .data_on (data_on),
        .wip     (wip),
        .rd_byte (mem_rdata),
        .io_out  (io_out),
        .io_oe   (io_oe)
    );

endmodule

// File: rtl/qread_engine_chk.sv
module qread_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              tick,
    input logic [3:0]        io_out,
    input logic [3:0]        io_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (io_oe == 4'h0 && io_out == 4'h0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !tick) |=> ($stable(io_out) && $stable(io_oe) && $stable(mem_addr))); // R9

    AST_SINGLE_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0010) |-> (io_out[3:2] == 2'b00 && io_out[0] == 1'b0)); // R10

    AST_DRIVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && io_oe != 4'h0) |=> (io_oe != 4'h0)); // R1

    AST_LANES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && io_oe != 4'h0) |=> $stable(io_oe)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && tick && io_oe != 4'h0) |=>
            (mem_addr == $past(mem_addr) ||
             mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7

endmodule

bind qread_engine qread_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .tick     (tick),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .mem_addr (mem_addr)
);

// File: tb/qread_engine_bench.sv
module qread_engine_bench;

    localparam int ADDR_W = 16;
    localparam int K_FAST = 0;
    localparam int K_QOUT = 1;
    localparam int K_QIO  = 2;
    localparam int K_CONT = 3;
    localparam int K_OTHER = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              tick = 1'b0;
    logic [3:0]        io_in = 4'h0;
    logic              wip = 1'b0;
    logic [7:0]        mem_rdata;
    logic [3:0]        io_out;
    logic [3:0]        io_oe;
    logic [ADDR_W-1:0] mem_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
    endfunction

    always_comb mem_rdata = memf(mem_addr);

    qread_engine #(.ADDR_W(ADDR_W)) u_qread_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .tick      (tick),
        .io_in     (io_in),
        .wip       (wip),
        .mem_rdata (mem_rdata),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .mem_addr  (mem_addr)
    );

    task automatic check(input string req, input logic [3:0] got_out, input logic [3:0] got_oe,
                         input logic [3:0] exp_out, input logic [3:0] exp_oe, input int t);
        n_checks++;
        if (got_out !== exp_out || got_oe !== exp_oe) begin
            n_fails++;
            $display("FAIL %s tick %0d: out=%h oe=%h expected out=%h oe=%h",
                     req, t, got_out, got_oe, exp_out, exp_oe);
        end
    endtask

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    // One transaction; reference model predicts the lanes after every tick.
    task automatic run_txn(input int kind, input logic [23:0] a, input int nbytes,
                           input logic [7:0] mbyte, input logic busy, input string req);
        logic [3:0] pre[$];
        logic [7:0] op;
        int         lpos, dlen;
        logic       quad;
        pre  = {};
        quad = (kind != K_FAST);
        op   = (kind == K_FAST) ? 8'h0B : (kind == K_QOUT) ? 8'h6B :
               (kind == K_QIO) ? 8'hEB : 8'h05;
        if (kind != K_CONT)
            for (int i = 7; i >= 0; i--) pre.push_back({3'b000, op[i]});
        if (kind == K_QIO || kind == K_CONT)
            for (int i = 5; i >= 0; i--) pre.push_back(a[i*4 +: 4]);
        else
            for (int i = 23; i >= 0; i--) pre.push_back({3'b000, a[i]});
        if (kind == K_FAST || kind == K_OTHER) begin
            for (int i = 0; i < 8; i++) pre.push_back(4'h0);
        end else begin
            pre.push_back(mbyte[7:4]);
            pre.push_back(mbyte[3:0]);
            for (int i = 0; i < 6; i++) pre.push_back(4'h0);
        end
        lpos = pre.size();
        dlen = (kind == K_FAST) ? nbytes * 8 : (kind == K_OTHER) ? 8 : nbytes * 2;
        wip  = busy;
        @(negedge clk);
        cs_n = 1'b0;
        for (int t = 1; t <= lpos + dlen; t++) begin
            logic [3:0]  e_out, e_oe;
            logic [7:0]  bval;
            logic [15:0] ea;
            int          k, b;
            @(negedge clk);
            io_in = (t <= lpos) ? pre[t-1] : 4'h0;
            tick  = 1'b1;
            @(negedge clk);
            tick  = 1'b0;
            e_out = 4'h0;
            e_oe  = 4'h0;
            if (kind != K_OTHER && t >= lpos) begin
                e_oe = quad ? 4'hF : 4'b0010;
                if (t > lpos) begin
                    k    = t - lpos - 1;
                    b    = quad ? k / 2 : k / 8;
                    ea   = a[15:0] + 16'(b);
                    bval = busy ? 8'h00 : memf(ea);
                    if (quad) e_out = (k % 2 == 0) ? bval[7:4] : bval[3:0];
                    else      e_out = {2'b00, bval[7 - (k % 8)], 1'b0};
                end
            end
            check(req, io_out, io_oe, e_out, e_oe, t);
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        check("R9 deselect", io_out, io_oe, 4'h0, 4'h0, 0);
        @(negedge clk);
        wip = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset", io_out, io_oe, 4'h0, 4'h0, 0);

        run_txn(K_FAST, 24'h000100, 5, 8'h00, 1'b0, "R1 fast read R7 increment");
        run_txn(K_QOUT, 24'h001234, 3, 8'hFF, 1'b0, "R2 quad output read");
        run_txn(K_FAST, 24'h000010, 2, 8'h00, 1'b0, "R4 mode bit 1 keeps command mode");
        run_txn(K_QIO,  24'h00ABCD, 3, 8'h20, 1'b0, "R3 quad io read");
        run_txn(K_CONT, 24'h000200, 2, 8'h70, 1'b0, "R5 continuous read R4 stay");
        run_txn(K_CONT, 24'h000300, 3, 8'h80, 1'b1, "R6 busy zeros in continuous");
        run_txn(K_OTHER, 24'h000400, 0, 8'h00, 1'b0, "R8 other opcode ignored");
        run_txn(K_FAST, 24'hABFFFE, 4, 8'h00, 1'b0, "R7 mask and wrap R8 next normal");
        run_txn(K_QOUT, 24'h000040, 2, 8'h00, 1'b0, "R4 quad output mode 0");
        run_txn(K_CONT, 24'h00FFFF, 3, 8'hC0, 1'b0, "R5 continuous after quad output R7 wrap");
        run_txn(K_FAST, 24'h000777, 2, 8'h00, 1'b1, "R6 busy zeros fast R10 lane");
        run_txn(K_QIO,  24'h000500, 2, 8'h80, 1'b0, "R4 quad io mode 1");
        run_txn(K_FAST, 24'h000020, 1, 8'h00, 1'b0, "R4 back to command mode");

        summary_and_end();
    end

endmodule